// File: doc/BRIEF.md
# Serial DAC Word Transmitter

This block takes signed 16-bit audio samples from a valid/ready source and turns each one into the three-wire waveform that loads a serial-input audio DAC: a divided serial clock, a data line that carries the word most significant bit first, and a latch strobe. The DAC's input register only commits the last bit after one more rising edge than there are data bits. The block therefore appends a seventeenth clock pulse after every word and frames the latch strobe around it. Between words the serial clock stops low and the latch strobe stays low, so the receiver sees a clean, separate frame for each sample.

The serial half-period is a whole number of system clocks, set by `HALF_DIV`. A gap of `GAP_HALVES` idle half-periods follows each frame, and this sets the word rate. With a 50 MHz system clock, `HALF_DIV = 3` gives an 8.33 MHz serial clock and `GAP_HALVES = 13` gives a spacing of 142 system clocks. That is about 352 kHz, or two channels at four times 44.1 kHz. A source that holds `in_valid` high and alternates left and right samples gets that interleaved stream.

Top module: `sdac_tx`

## Requirements
- R1: Every accepted word is sent as `WORD_W` data bits, bit `WORD_W-1` first and bit 0 last, unchanged in value (two's complement passes through untouched).
- R2: `ser_data` changes only in a cycle where `ser_clk` is low. It holds its value in the cycle of each rising `ser_clk` edge and through the whole high half that follows.
- R3: `ser_latch` rises after the high half of the last data bit and stays high for exactly one serial period (`2*HALF_DIV` system clocks). During that time the extra commit pulse runs. `ser_latch` then falls together with the falling edge that ends that pulse.
- R4: Each frame contains exactly `WORD_W+1` rising `ser_clk` edges. Between frames `ser_clk` rests low and `ser_latch` stays low until the next frame's commit pulse.
- R5: Every `ser_clk` high half lasts `HALF_DIV` system clocks. Rising edges within a frame are `2*HALF_DIV` system clocks apart.
- R6: `in_ready` is high only while no frame is in progress. A word is taken on a rising edge with `in_valid` and `in_ready` both high, and `in_ready` is low in the next cycle. `in_valid` while `in_ready` is low has no effect on the stream.
- R7: The most significant bit is on `ser_data` after the second rising edge, counting the accepting edge as the first. `in_ready` returns high `(2*(WORD_W+1)+GAP_HALVES)*HALF_DIV` cycles after the accepting edge, which is 141 with the defaults.
- R8: While `rst_n` is low, `ser_clk`, `ser_data` and `ser_latch` are low and `in_ready` is high. A reset in the middle of a frame abandons that frame.
- R9: With `in_valid` held high, successive words are accepted every `(2*(WORD_W+1)+GAP_HALVES)*HALF_DIV+1` system clocks, which is 142 with the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample offered by the source |
| in_ready | output | 1 | Block is idle and can take a sample |
| in_word | input | WORD_W | Two's-complement sample |
| ser_clk | output | 1 | Serial clock to the DAC |
| ser_data | output | 1 | Serial data, most significant bit first |
| ser_latch | output | 1 | Latch strobe; its falling edge commits the word |

## Verification
The hold assertion on the data line assumes `HALF_DIV` is at least 2, so that no high half is shorter than one system clock past the rising edge. The bench keeps the default of 3. The checks assume `in_word` is stable whenever `in_valid` and `in_ready` are both high. The bench changes the word and `in_valid` only on falling system-clock edges, so the accepting edge sees settled values. The window counters of the checkers restart at reset. The bench pulls reset mid-frame only with a following idle period, so no frame spans a reset.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  typedef struct packed {
    logic sclk;
    logic le;
    logic dat_en;
  } wave_t;

  // Half-periods in a frame: data bits plus the commit pulse, then the gap.
  function automatic int unsigned frame_halves(input int unsigned word_w,
                                               input int unsigned gap_h);
    return 2 * (word_w + 1) + gap_h;
  endfunction

  // Waveform levels for half-period h of a running frame.
  function automatic wave_t wave_of(input logic busy, input int unsigned h,
                                    input int unsigned word_w);
    wave_t w;
    w = '0;
    if (busy && h < 2 * (word_w + 1)) begin
      w.sclk   = h[0];
      w.le     = (h >= 2 * word_w);
      w.dat_en = (h < 2 * word_w);
    end
    return w;
  endfunction

endpackage

// File: rtl/sdac_tick.sv
module sdac_tick #(
  parameter int HALF_DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic half_end
);
  localparam int DW = $clog2(HALF_DIV + 1);
  localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);

  logic [DW-1:0] div_q;

  assign half_end = run && (div_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else if (!run || half_end) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end

  generate
    if (HALF_DIV > 1) begin : g_gap
      // R5
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_end |=> !half_end);
    end
  endgenerate

endmodule

// File: rtl/sdac_seq.sv
module sdac_seq #(
  parameter int FRAME_H = 47,
  parameter int PH_W    = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            half_end,
  output logic            busy,
  output logic [PH_W-1:0] ph,
  output logic            accept
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(FRAME_H - 1);

  logic            busy_q;
  logic [PH_W-1:0] ph_q;
  logic            frame_done;

  assign accept     = in_valid && !busy_q;
  assign frame_done = half_end && (ph_q == PH_LAST);
  assign busy       = busy_q;
  assign ph         = ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      ph_q   <= '0;
    end else if (frame_done) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
    end else if (half_end) begin
      ph_q <= ph_q + 1'b1;
    end
  end

  // R6
  accept_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(in_valid));

endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              adv,
  output logic              msb
);
  logic [WORD_W-1:0] sh_q;

  assign msb = sh_q[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else if (load) sh_q <= load_word;
    else if (adv) sh_q <= {sh_q[WORD_W-2:0], 1'b0};
  end

endmodule

// File: rtl/sdac_tx.sv
module sdac_tx #(
  parameter int WORD_W     = 16,
  parameter int HALF_DIV   = 3,
  parameter int GAP_HALVES = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              ser_latch
);
  import sdac_pkg::*;

  localparam int FRAME_H = int'(frame_halves(WORD_W, GAP_HALVES));
  localparam int PH_W    = $clog2(FRAME_H + 1);
  localparam int LW      = $clog2(2 * HALF_DIV + 2) + 1;
  localparam int RW      = $clog2(WORD_W + 3) + 1;

  logic            busy;
  logic [PH_W-1:0] ph;
  logic            half_end;
  logic            accept;
  logic            adv;
  logic            msb;
  wave_t           wv;

  sdac_tick #(.HALF_DIV(HALF_DIV)) tick_i (
    .clk(clk), .rst_n(rst_n), .run(busy), .half_end(half_end)
  );

  sdac_seq #(.FRAME_H(FRAME_H), .PH_W(PH_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .half_end(half_end),
    .busy(busy), .ph(ph), .accept(accept)
  );

  // Advance to the next bit as each odd (high) half of a data bit ends.
  assign adv = half_end && ph[0] && (ph < PH_W'(2 * WORD_W - 2));

  sdac_shift #(.WORD_W(WORD_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_word(in_word),
    .adv(adv), .msb(msb)
  );

  assign in_ready = !busy;
  assign wv = wave_of(busy, 32'(ph), WORD_W);

  // Registered pins: no decode glitches reach the DAC.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_clk   <= 1'b0;
      ser_data  <= 1'b0;
      ser_latch <= 1'b0;
    end else begin
      ser_clk   <= wv.sclk;
      ser_data  <= wv.dat_en & msb;
      ser_latch <= wv.le;
    end
  end

  // Window counters for the checks below.
  logic [LW-1:0] le_run_q;
  logic [RW-1:0] rise_cnt_q;
  logic          clk_prev_q;
  logic          latch_prev_q;
  logic          sclk_rise_ev;
  logic          latch_fall_ev;

  assign sclk_rise_ev  = ser_clk && !clk_prev_q;
  assign latch_fall_ev = latch_prev_q && !ser_latch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      le_run_q     <= '0;
      rise_cnt_q   <= '0;
      clk_prev_q   <= 1'b0;
      latch_prev_q <= 1'b0;
    end else begin
      clk_prev_q   <= ser_clk;
      latch_prev_q <= ser_latch;
      le_run_q     <= ser_latch ? le_run_q + 1'b1 : '0;
      if (latch_fall_ev) rise_cnt_q <= '0;
      else if (sclk_rise_ev) rise_cnt_q <= rise_cnt_q + 1'b1;
    end
  end

  // R2
  data_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_data));

  // R3
  latch_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_fall_ev |-> (le_run_q == LW'(2 * HALF_DIV)) && $fell(ser_clk));

  // R4
  rise_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_fall_ev |-> rise_cnt_q == RW'(WORD_W + 1));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && $past(in_ready)) |-> (!ser_clk && !ser_latch));

  // R6
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

endmodule

// File: tb/sdac_tx_tb_top.sv
module sdac_tx_tb_top;
  localparam int W    = 16;
  localparam int D    = 3;
  localparam int GAP  = 13;
  localparam int BUSY_CYC = (2 * W + 2 + GAP) * D;   // 141
  localparam int SPACING  = BUSY_CYC + 1;           // 142

  // {idle cycles before offer, word}
  localparam logic [23:0] VEC [0:7] = '{
    {8'd0,  16'h0000}, {8'd5,  16'h7FFF}, {8'd0,  16'h8000}, {8'd9,  16'hFFFF},
    {8'd1,  16'hA5C3}, {8'd0,  16'h0001}, {8'd30, 16'h5A3C}, {8'd2,  16'h8001}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_word = '0;
  logic in_ready, ser_clk, ser_data, ser_latch;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [W-1:0] expq [0:63];
  int wr = 0;
  int rd = 0;
  int frames = 0;

  sdac_tx #(.WORD_W(W), .HALF_DIV(D), .GAP_HALVES(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_latch(ser_latch)
  );

  always #10 clk = ~clk;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R7 watchdog actual %0d expected below %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Behavioural receiver built from the requirements.
  logic p_clk = 1'b0, p_dat = 1'b0, p_le = 1'b0;
  logic [W:0] rx = '0;
  int rises = 0, since = 0, hi_run = 0, le_hi = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_clk = 1'b0; p_dat = 1'b0; p_le = 1'b0;
      rx = '0; rises = 0; since = 0; hi_run = 0; le_hi = 0;
    end else begin
      since++;
      if (ser_clk && !p_clk) begin
        check(ser_data == p_dat, "R2 setup", ser_data, p_dat);
        if (rises > 0) check(since == 2 * D, "R5 rise spacing", since, 2 * D);
        rx = {rx[W-1:0], ser_data};
        rises++;
        since = 0;
      end
      if (ser_clk && ser_data != p_dat) check(1'b0, "R2 hold", ser_data, p_dat);
      if (ser_clk) hi_run++;
      if (!ser_clk && p_clk) begin
        check(hi_run == D, "R5 high width", hi_run, D);
        hi_run = 0;
      end
      if (ser_latch) le_hi++;
      if (!ser_latch && p_le) begin
        check(le_hi == 2 * D, "R3 latch width", le_hi, 2 * D);
        check(!ser_clk && p_clk, "R3 latch falls with clock", ser_clk, 0);
        check(rises == W + 1, "R4 rising edges", rises, W + 1);
        if (rd == wr) check(1'b0, "R6 unexpected frame", rx[W:1], 0);
        else begin
          check(rx[W:1] == expq[rd[5:0]], "R1 word", rx[W:1], expq[rd[5:0]]);
          rd++;
        end
        frames++;
        rises = 0; le_hi = 0;
      end
      p_clk = ser_clk; p_dat = ser_data; p_le = ser_latch;
    end
  end

  // Offer a word; returns at the falling edge right after the accepting edge.
  task automatic send(input logic [W-1:0] w);
    in_valid = 1'b1;
    in_word = w;
    while (!in_ready) @(negedge clk);
    expq[wr[5:0]] = w;
    wr++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 2000 && rd != wr; k++) @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int n;
    int t0;
    int f0;
    // R8 reset state
    repeat (3) @(negedge clk);
    check(!ser_clk && !ser_data && !ser_latch, "R8 pins in reset",
          {ser_clk, ser_data, ser_latch}, 0);
    check(in_ready, "R8 ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 vector walk
    for (int i = 0; i < 8; i++) begin
      repeat (int'(VEC[i][23:16])) @(negedge clk);
      send(VEC[i][15:0]);
    end
    drain();
    check(rd == 8 && frames == 8, "R1 frames delivered", frames, 8);
    check(!ser_clk && !ser_latch, "R4 idle clock stopped", {ser_clk, ser_latch}, 0);

    // R7 first-bit timing and ready latency
    send(16'h8000);
    check(!ser_data && !in_ready, "R7 no data on accepting edge", ser_data, 0);
    n = 0;
    @(negedge clk); n++;
    check(ser_data && !ser_clk, "R7 MSB after second edge", ser_data, 1);
    while (!in_ready) begin @(negedge clk); n++; end
    check(n == BUSY_CYC, "R7 ready latency", n, BUSY_CYC);
    drain();

    // R9 back-to-back spacing with valid held
    in_valid = 1'b1;
    in_word = 16'h1234;
    while (!in_ready) @(negedge clk);
    t0 = cyc;
    expq[wr[5:0]] = 16'h1234; wr++;
    @(negedge clk);
    in_word = 16'hFEDC;
    while (!in_ready) @(negedge clk);
    check(cyc - t0 == SPACING, "R9 word spacing", cyc - t0, SPACING);
    expq[wr[5:0]] = 16'hFEDC; wr++;
    @(negedge clk);
    in_valid = 1'b0;
    drain();

    // R6 offers while busy are ignored
    send(16'h0F0F);
    f0 = frames;
    in_valid = 1'b1;
    in_word = 16'hDEAD;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (k == 10) check(!in_ready, "R6 ready low while busy", in_ready, 0);
    end
    in_valid = 1'b0;
    drain();
    repeat (400) @(negedge clk);
    check(frames == f0 + 1, "R6 busy offer ignored", frames, f0 + 1);
    check(in_ready, "R6 idle after frame", in_ready, 1);

    // R8 reset mid-frame
    send(16'hC33C);
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!ser_clk && !ser_data && !ser_latch, "R8 mid-frame reset pins",
          {ser_clk, ser_data, ser_latch}, 0);
    check(in_ready, "R8 mid-frame reset ready", in_ready, 1);
    rd = wr;
    rst_n = 1'b1;
    repeat (300) @(negedge clk);
    check(!ser_latch && !ser_clk, "R8 frame abandoned", {ser_clk, ser_latch}, 0);
    send(16'h2468);
    drain();
    check(rd == wr, "R1 word after reset", rd, wr);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule